// File: doc/BRIEF.md
# Random Multiport Memory Test Sequencer

This block is a built-in self-test engine for a memory with several access ports. When started, it drives every port with a pseudo-random stream of commands. Each port, in each cycle, is idle, writes a full word, writes some segments of a word, or reads. The engine keeps its own shadow copy of every word it has written, with a valid bit for each address. It checks every word the memory returns against that shadow copy.

A run always has the same shape. It opens with one idle cycle. Next comes a seeding stretch of full writes, then one cycle in which every port reads the same stored address. After that come a configurable number of random cycles, and the run closes with one idle cycle. The random choices follow rules that keep the test meaningful:

- No port touches an address that a lower-numbered port writes in the same cycle.
- Write data is never trivial.
- Partial writes only go to words that hold known data.

The first mismatch is latched, together with the port and the cycle index of the offending read.

Ports `0 .. RW_PORTS-1` can read and write. The remaining `RO_PORTS` ports only read. The memory is expected to return read data in the cycle after the read command.

Top module: `memtest_seq`

## Requirements
- R1: A run lasts `RAND_CYCLES+6` cycles, indexed from 0. Cycle 0 is the first cycle after the edge that samples `start`. In cycle 0 and in the final cycle `RAND_CYCLES+5`, no port asserts chip select.
- R2: In cycles 1 to 3, port 0 always does a full write, meaning `mem_we`=1 and every mask bit is 1. The other read-write ports either do a full write or stay idle. Read-only ports stay idle.
- R3: In cycle 4, every port reads, and all ports present one and the same address.
- R4: Cycles 5 to `RAND_CYCLES+4` are random. A read-write port picks idle, full write, partial write or read, and reads come up about twice as often as each of the other choices. A read-only port picks idle or read and never asserts `mem_we`.
- R5: Every written data word is neither all zeros nor all ones.
- R6: Bit i of a port's mask enables data bits `[i*SEG_W+SEG_W-1 : i*SEG_W]`. A partial write has a mask that is neither all zeros nor all ones, and it only targets an address already written in this run.
- R7: Take two active ports in the same cycle where at least one of them writes. They never present the same address. The higher-numbered port is the one that is made idle.
- R8: A read only targets an address written earlier in the same run.
- R9: `mem_rdata` for a read is compared at the end of the cycle after the command. The expected value is the last full-write data, with partial writes merged in segment by segment according to the mask. A correct memory never causes a failure.
- R10: `fail` rises in the cycle after the compare that mismatched, and then holds. `fail_port` gives the lowest mismatching port of that compare. `fail_cycle` gives the index of that read's command cycle. Later mismatches do not change any of the three.
- R11: After reset, `done` and `fail` are low. `done` rises in the cycle after the final idle cycle and stays high.
- R12: `start` is ignored while a run is in progress. A new start clears `fail` and forgets every stored address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when not busy |
| seed | input | 32 | Seed for the pseudo-random generators |
| mem_cs | output | NP | Per-port chip select |
| mem_we | output | NP | Per-port write enable |
| mem_addr | output | NP*ADDR_W | Per-port address, port p at `[p*ADDR_W +: ADDR_W]` |
| mem_wdata | output | NP*DATA_W | Per-port write data |
| mem_wmask | output | NP*DATA_W/SEG_W | Per-port segment write enables |
| mem_rdata | input | NP*DATA_W | Per-port read data, one cycle after the read |
| done | output | 1 | Run finished |
| fail | output | 1 | Mismatch seen in this run |
| fail_port | output | max(1,clog2(NP)) | Port of first mismatch |
| fail_cycle | output | clog2(RAND_CYCLES+6) | Command cycle of first mismatch |

## Verification
The command pattern is due in the same cycle as its phase, so the bench samples the ports at the falling edge of each cycle and judges them against the index of that cycle in the run. Read data is due one cycle after the command. The bench's memory model computes that data from its own stored words at the falling edge and drives it just after the next rising edge. A deliberately corrupted word must therefore raise `fail` exactly two cycles after its command, and not one cycle after. The bench checks both of those cycles, then checks the latched port and cycle index. It checks `done` in the final idle cycle and in the cycle after it.

// File: rtl/mts_pkg.sv
package mts_pkg;
   typedef enum logic [2:0] {PH_IDLE, PH_FIRST, PH_SEED, PH_ALLRD, PH_RAND, PH_LAST, PH_DONE} phase_t;
   typedef enum logic [1:0] {OP_NOP, OP_WR, OP_PW, OP_RD} op_t;

   localparam int SEED_WRITES = 3;

   function automatic logic is_wr(input op_t o);
      return (o == OP_WR) || (o == OP_PW);
   endfunction
endpackage

// File: rtl/mts_lfsr.sv
// Per-port pseudo-random word: 64-bit shift register advanced 32 places per cycle.
module mts_lfsr #(
   parameter int          OUT_W = 30,
   parameter logic [31:0] SALT  = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [31:0]       seed,
   output logic [OUT_W-1:0]  rnd
);
   localparam int SW    = 64;
   localparam int STEPS = 32;

   logic [SW-1:0] st;

   function automatic logic [SW-1:0] adv(input logic [SW-1:0] s);
      logic [SW-1:0] t;
      t = s;
      for (int i = 0; i < STEPS; i++)
         t = {t[SW-2:0], t[63] ^ t[62] ^ t[60] ^ t[59]};
      return t;
   endfunction

   initial begin
      assert (OUT_W >= 1 && OUT_W <= SW) else $error("mts_lfsr: OUT_W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st <= 64'h1;
      else if (load) st <= {seed ^ SALT, seed | 32'h1};
      else if (step) st <= adv(st);
   end

   assign rnd = st[OUT_W-1:0];
endmodule

// File: rtl/mts_pick.sv
// Chooses one port's operation, address, data and mask for the current phase.
module mts_pick import mts_pkg::*; #(
   parameter int DW    = 16,
   parameter int AW    = 4,
   parameter int NM    = 4,
   parameter bit IS_RW = 1'b1,
   parameter int RB    = 6 + AW + DW + NM
) (
   input  phase_t              phase,
   input  logic [RB-1:0]       rnd,
   input  logic [(1<<AW)-1:0]  valid,
   input  logic [AW-1:0]       last_wr,
   input  logic [AW-1:0]       share_addr,
   output op_t                 op,
   output logic [AW-1:0]       addr,
   output logic [AW-1:0]       vaddr,
   output logic [DW-1:0]       data,
   output logic [NM-1:0]       mask
);
   logic [5:0]    f_op;
   logic [AW-1:0] f_a;
   logic [DW-1:0] f_d;
   logic [NM-1:0] f_m;
   logic [NM-1:0] pm;
   op_t           rop;

   assign f_op = rnd[5:0];
   assign f_a  = rnd[6 +: AW];
   assign f_d  = rnd[6+AW +: DW];
   assign f_m  = rnd[6+AW+DW +: NM];

   // stored address for reads and partial writes; falls back to the latest write
   assign vaddr = valid[f_a] ? f_a : last_wr;

   generate
      if (!IS_RW) begin : g_ro
         assign rop = (f_op % 6'd2 == 6'd0) ? OP_NOP : OP_RD;
      end else if (NM == 1) begin : g_full
         always_comb begin
            case (f_op % 6'd4)
               6'd0:    rop = OP_NOP;
               6'd1:    rop = OP_WR;
               default: rop = OP_RD;
            endcase
         end
      end else begin : g_part
         always_comb begin
            case (f_op % 6'd5)
               6'd0:    rop = OP_NOP;
               6'd1:    rop = OP_WR;
               6'd2:    rop = OP_PW;
               default: rop = OP_RD;
            endcase
         end
      end

      if (NM > 1) begin : g_mfix
         always_comb begin
            pm = f_m;
            if (f_m == '0)  pm[0] = 1'b1;
            else if (&f_m)  pm[0] = 1'b0;
         end
      end else begin : g_mone
         assign pm = '1;
      end
   endgenerate

   always_comb begin
      data = f_d;
      if (f_d == '0)  data[0] = 1'b1;
      else if (&f_d)  data[0] = 1'b0;
   end

   always_comb begin
      op   = OP_NOP;
      addr = f_a;
      mask = '1;
      case (phase)
         PH_SEED:  op = IS_RW ? OP_WR : OP_NOP;
         PH_ALLRD: begin
            op   = OP_RD;
            addr = share_addr;
         end
         PH_RAND: begin
            op = rop;
            if (rop == OP_RD || rop == OP_PW) addr = vaddr;
            if (rop == OP_PW) mask = pm;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/memtest_seq.sv
module memtest_seq import mts_pkg::*; #(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 4,
   parameter int SEG_W       = 4,
   parameter int RW_PORTS    = 2,
   parameter int RO_PORTS    = 1,
   parameter int RAND_CYCLES = 40,
   localparam int NP   = RW_PORTS + RO_PORTS,
   localparam int NM   = DATA_W / SEG_W,
   localparam int PIW  = (NP > 1) ? $clog2(NP) : 1,
   localparam int LAST_CYC = 5 + RAND_CYCLES,
   localparam int CW   = $clog2(LAST_CYC + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [31:0]          seed,
   output logic [NP-1:0]        mem_cs,
   output logic [NP-1:0]        mem_we,
   output logic [NP*ADDR_W-1:0] mem_addr,
   output logic [NP*DATA_W-1:0] mem_wdata,
   output logic [NP*NM-1:0]     mem_wmask,
   input  logic [NP*DATA_W-1:0] mem_rdata,
   output logic                 done,
   output logic                 fail,
   output logic [PIW-1:0]       fail_port,
   output logic [CW-1:0]        fail_cycle
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int RB    = 6 + ADDR_W + DATA_W + NM;

   initial begin
      assert (DATA_W % SEG_W == 0) else $error("memtest_seq: DATA_W must be a multiple of SEG_W");
      assert (RW_PORTS >= 1)       else $error("memtest_seq: need a read-write port");
      assert (RB <= 64)            else $error("memtest_seq: random field too wide");
      assert (RAND_CYCLES >= 1)    else $error("memtest_seq: RAND_CYCLES must be positive");
   end

   phase_t              phase;
   logic [CW-1:0]       cyc;
   logic [DATA_W-1:0]   shadow [DEPTH];
   logic [DEPTH-1:0]    valid;
   logic [ADDR_W-1:0]   last_wr;
   logic [ADDR_W-1:0]   share_addr;
   op_t                 pk_op   [NP];
   op_t                 eff_op  [NP];
   logic [ADDR_W-1:0]   pk_addr [NP];
   logic [ADDR_W-1:0]   pk_vaddr[NP];
   logic [DATA_W-1:0]   pk_data [NP];
   logic [NM-1:0]       pk_mask [NP];
   logic [RB-1:0]       rnd     [NP];
   logic [NP-1:0]       chk_vld;
   logic [DATA_W-1:0]   chk_exp [NP];
   logic [CW-1:0]       chk_cyc;
   logic                load;
   logic                running;

   assign load       = start && (phase == PH_IDLE || phase == PH_DONE);
   assign running    = (phase != PH_IDLE) && (phase != PH_DONE);
   assign share_addr = pk_vaddr[0];
   assign done       = (phase == PH_DONE);

   // ---------------- per-port generators ----------------
   generate
      for (genvar g = 0; g < NP; g++) begin : g_port
         mts_lfsr #(.OUT_W(RB), .SALT(32'h9E37_79B9 * (g + 1))) u_rng (
            .clk(clk), .rst_n(rst_n), .load(load), .step(running),
            .seed(seed), .rnd(rnd[g]));

         mts_pick #(.DW(DATA_W), .AW(ADDR_W), .NM(NM), .IS_RW(g < RW_PORTS), .RB(RB)) u_pick (
            .phase(phase), .rnd(rnd[g]), .valid(valid), .last_wr(last_wr),
            .share_addr(share_addr), .op(pk_op[g]), .addr(pk_addr[g]),
            .vaddr(pk_vaddr[g]), .data(pk_data[g]), .mask(pk_mask[g]));

         assign mem_cs[g]                    = (eff_op[g] != OP_NOP);
         assign mem_we[g]                    = is_wr(eff_op[g]);
         assign mem_addr[g*ADDR_W +: ADDR_W] = pk_addr[g];
         assign mem_wdata[g*DATA_W +: DATA_W] = pk_data[g];
         assign mem_wmask[g*NM +: NM]        = is_wr(eff_op[g]) ? pk_mask[g] : '0;
      end
   endgenerate

   // ---------------- same-cycle address conflicts: lower port wins ----------------
   always_comb begin
      for (int p = 0; p < NP; p++) begin
         eff_op[p] = pk_op[p];
         for (int q = 0; q < p; q++) begin
            if (eff_op[q] != OP_NOP && (is_wr(eff_op[q]) || is_wr(pk_op[p]))
                && pk_addr[q] == pk_addr[p])
               eff_op[p] = OP_NOP;
         end
      end
   end

   // ---------------- phase sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cyc   <= '0;
      end else begin
         case (phase)
            PH_IDLE, PH_DONE: if (start) begin
               phase <= PH_FIRST;
               cyc   <= '0;
            end
            PH_FIRST: begin
               phase <= PH_SEED;
               cyc   <= cyc + 1'b1;
            end
            PH_SEED: begin
               if (cyc == CW'(SEED_WRITES)) phase <= PH_ALLRD;
               cyc <= cyc + 1'b1;
            end
            PH_ALLRD: begin
               phase <= PH_RAND;
               cyc   <= cyc + 1'b1;
            end
            PH_RAND: begin
               if (cyc == CW'(LAST_CYC - 1)) phase <= PH_LAST;
               cyc <= cyc + 1'b1;
            end
            PH_LAST: phase <= PH_DONE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // ---------------- shadow copy ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid   <= '0;
         last_wr <= '0;
      end else if (load) begin
         valid <= '0;
      end else begin
         for (int p = 0; p < NP; p++) begin
            if (mem_we[p]) begin
               valid[pk_addr[p]] <= 1'b1;
               last_wr           <= pk_addr[p];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int p = 0; p < NP; p++)
         if (mem_we[p])
            for (int s = 0; s < NM; s++)
               if (pk_mask[p][s])
                  shadow[pk_addr[p]][s*SEG_W +: SEG_W] <= pk_data[p][s*SEG_W +: SEG_W];
   end

   // ---------------- read compare ----------------
   always_ff @(posedge clk) begin
      for (int p = 0; p < NP; p++)
         if (mem_cs[p] && !mem_we[p]) chk_exp[p] <= shadow[pk_addr[p]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_vld    <= '0;
         chk_cyc    <= '0;
         fail       <= 1'b0;
         fail_port  <= '0;
         fail_cycle <= '0;
      end else if (load) begin
         chk_vld    <= '0;
         fail       <= 1'b0;
         fail_port  <= '0;
         fail_cycle <= '0;
      end else begin
         chk_vld <= mem_cs & ~mem_we;
         chk_cyc <= cyc;
         if (!fail) begin
            for (int p = NP - 1; p >= 0; p--) begin
               if (chk_vld[p] && mem_rdata[p*DATA_W +: DATA_W] != chk_exp[p]) begin
                  fail       <= 1'b1;
                  fail_port  <= PIW'(p);
                  fail_cycle <= chk_cyc;
               end
            end
         end
      end
   end

   // ---------------- assertions ----------------
   p_edges_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_FIRST || phase == PH_LAST) |-> mem_cs == '0);

   p_fail_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> (fail && $stable(fail_cycle) && $stable(fail_port)));

   p_done_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(phase) == PH_LAST);

   generate
      for (genvar g = 0; g < NP; g++) begin : g_chk
         p_data_nontrivial_r5: assert property (@(posedge clk) disable iff (!rst_n)
            mem_we[g] |-> (mem_wdata[g*DATA_W +: DATA_W] != '0 && mem_wdata[g*DATA_W +: DATA_W] != '1));

         p_mask_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            mem_we[g] |-> mem_wmask[g*NM +: NM] != '0);

         p_partial_stored_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_we[g] && mem_wmask[g*NM +: NM] != '1) |-> valid[mem_addr[g*ADDR_W +: ADDR_W]]);

         p_read_stored_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_cs[g] && !mem_we[g]) |-> valid[mem_addr[g*ADDR_W +: ADDR_W]]);

         p_allread_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (phase == PH_ALLRD) |-> (mem_cs[g] && !mem_we[g]
                                     && mem_addr[g*ADDR_W +: ADDR_W] == mem_addr[0 +: ADDR_W]));

         if (g >= RW_PORTS) begin : g_ro
            p_seed_ro_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
               (phase == PH_SEED) |-> !mem_cs[g]);
         end else begin : g_rw
            p_seed_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
               (phase == PH_SEED && mem_cs[g]) |-> (mem_we[g] && mem_wmask[g*NM +: NM] == '1));
         end

         for (genvar q = 0; q < NP; q++) begin : g_pair
            if (q < g) begin : g_lo
               p_no_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
                  (mem_cs[g] && mem_cs[q] && (mem_we[g] || mem_we[q]))
                  |-> mem_addr[g*ADDR_W +: ADDR_W] != mem_addr[q*ADDR_W +: ADDR_W]);
            end
         end
      end
   endgenerate
endmodule

// File: tb/memtest_seq_tb.sv
`timescale 1ns/1ps
module memtest_seq_tb;
   localparam int DW = 16, AW = 4, SEG = 4, NRW = 2, NRO = 1, NC = 40;
   localparam int NP = NRW + NRO, NM = DW / SEG, DEPTH = 1 << AW;
   localparam int LASTC = 5 + NC;
   localparam int CW = $clog2(LASTC + 1);
   localparam int PIW = 2;

   logic               clk = 1'b0;
   logic               rst_n, start;
   logic [31:0]        seed;
   logic [NP-1:0]      mem_cs, mem_we;
   logic [NP*AW-1:0]   mem_addr;
   logic [NP*DW-1:0]   mem_wdata;
   logic [NP*NM-1:0]   mem_wmask;
   logic [NP*DW-1:0]   mem_rdata;
   logic               done, fail;
   logic [PIW-1:0]     fail_port;
   logic [CW-1:0]      fail_cycle;

   always #2 clk = ~clk;

   memtest_seq #(.DATA_W(DW), .ADDR_W(AW), .SEG_W(SEG), .RW_PORTS(NRW),
                 .RO_PORTS(NRO), .RAND_CYCLES(NC)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
      .mem_cs(mem_cs), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_wmask(mem_wmask), .mem_rdata(mem_rdata), .done(done), .fail(fail),
      .fail_port(fail_port), .fail_cycle(fail_cycle));

   logic [DW-1:0]    mem [DEPTH];
   logic [DEPTH-1:0] bv;
   int n_chk = 0, n_fail = 0;
   int n_rd = 0, n_fw = 0, n_pw = 0;
   bit fin = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] ad(input int p);
      return mem_addr[p*AW +: AW];
   endfunction

   // mode 0: clean memory; 1: corrupt last port in the all-read cycle;
   // 2: corrupt every read from the first random-phase read onward
   task automatic run(input logic [31:0] s, input int mode, input bit busy_pulse);
      logic [DW-1:0] rdn [NP];
      int  inj_c, inj_p;
      bit  inj_on;
      inj_c = -1; inj_p = 0; inj_on = 0;
      bv = '0;
      @(negedge clk);
      start = 1'b1; seed = s;
      for (int c = 0; c <= LASTC + 1; c++) begin
         @(negedge clk);
         if (c == 0) start = 1'b0;
         if (busy_pulse && c == 10) start = 1'b1;
         if (busy_pulse && c == 11) start = 1'b0;
         if (c == 0) begin
            chk(!fail, "R12 start clears fail", fail, 0);
            chk(!done, "R11 done low while running", done, 0);
         end
         if (c == 0 || c == LASTC) chk(mem_cs == '0, "R1 idle first/last cycle", mem_cs, 0);
         if (c == LASTC) chk(!done, "R11 done low in last idle cycle", done, 0);
         if (c == LASTC + 1) chk(done, busy_pulse ? "R12 start ignored while busy" : "R11 done after last idle", done, 1);
         for (int p = 0; p < NP; p++) rdn[p] = '0;
         if (c >= 1 && c <= 3) begin
            chk(mem_cs[0] && mem_we[0], "R2 port 0 writes in seeding", {mem_cs[0], mem_we[0]}, 3);
            for (int p = 0; p < NP; p++) begin
               if (p >= NRW) chk(!mem_cs[p], "R2 read-only port idle in seeding", mem_cs[p], 0);
               else if (mem_cs[p])
                  chk(mem_we[p] && mem_wmask[p*NM +: NM] == '1, "R2 seeding writes are full",
                      mem_wmask[p*NM +: NM], {NM{1'b1}});
            end
         end
         if (c == 4)
            for (int p = 0; p < NP; p++)
               chk(mem_cs[p] && !mem_we[p] && ad(p) == ad(0), "R3 all ports read one address",
                   ad(p), ad(0));
         if (c >= 5 && c < LASTC)
            for (int p = 0; p < NP; p++) begin
               if (p >= NRW) chk(!mem_we[p], "R4 read-only port never writes", mem_we[p], 0);
               else if (mem_cs[p]) begin
                  if (!mem_we[p]) n_rd++;
                  else if (mem_wmask[p*NM +: NM] == '1) n_fw++;
                  else n_pw++;
               end
            end
         for (int p = 0; p < NP; p++) begin
            if (mem_we[p]) begin
               chk(mem_wdata[p*DW +: DW] != '0 && mem_wdata[p*DW +: DW] != '1,
                   "R5 write data nontrivial", mem_wdata[p*DW +: DW], 1);
               if (mem_wmask[p*NM +: NM] != '1)
                  chk(mem_wmask[p*NM +: NM] != '0 && bv[ad(p)], "R6 partial write mask/target",
                      {bv[ad(p)], mem_wmask[p*NM +: NM]}, 1);
            end
            for (int q = 0; q < p; q++)
               if (mem_cs[p] && mem_cs[q] && (mem_we[p] || mem_we[q]))
                  chk(ad(p) != ad(q), "R7 no same-address clash", ad(p), ad(q) + 1);
         end
         for (int p = 0; p < NP; p++) begin
            if (mem_cs[p] && !mem_we[p]) begin
               chk(bv[ad(p)], "R8 read of stored address", bv[ad(p)], 1);
               rdn[p] = mem[ad(p)];
               if (mode == 2 && c >= 5 && !inj_on) begin
                  inj_on = 1; inj_c = c; inj_p = p;
               end
               if ((mode == 1 && c == 4 && p == NP - 1) || (mode == 2 && inj_on))
                  rdn[p] = rdn[p] ^ 16'h0001;
            end
         end
         for (int p = 0; p < NP; p++)
            if (mem_we[p]) begin
               for (int sg = 0; sg < NM; sg++)
                  if (mem_wmask[p*NM + sg]) mem[ad(p)][sg*SEG +: SEG] = mem_wdata[p*DW + sg*SEG +: SEG];
               bv[ad(p)] = 1'b1;
            end
         if (mode == 1 && c == 5) chk(!fail, "R9 no fail before compare edge", fail, 0);
         if (mode == 1 && c == 6) chk(fail, "R9 fail after compare edge", fail, 1);
         if (mode == 2 && inj_on && c == inj_c + 1) chk(!fail, "R9 no early fail", fail, 0);
         if (mode == 2 && inj_on && c == inj_c + 2) chk(fail, "R9 fail two cycles after read", fail, 1);
         @(posedge clk);
         #1;
         for (int p = 0; p < NP; p++) mem_rdata[p*DW +: DW] = rdn[p];
      end
      if (mode == 0) chk(!fail, "R9 correct memory never fails", fail, 0);
      if (mode == 1) begin
         chk(fail, "R10 fail latched", fail, 1);
         chk(fail_port == PIW'(NP - 1), "R10 fail port", fail_port, NP - 1);
         chk(fail_cycle == CW'(4), "R10 fail cycle", fail_cycle, 4);
      end
      if (mode == 2) begin
         chk(inj_c >= 0 && fail, "R10 first mismatch latched", fail, 1);
         chk(fail_port == PIW'(inj_p), "R10 lowest port of first mismatch", fail_port, inj_p);
         chk(fail_cycle == CW'(inj_c), "R10 cycle of first mismatch", fail_cycle, inj_c);
      end
   endtask

   task automatic finish_up();
      if (!fin) begin
         fin = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; seed = '0; mem_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !fail, "R11 reset state", {done, fail}, 0);
      chk(mem_cs == '0, "R1 idle after reset", mem_cs, 0);
      run(32'h1234_5678, 0, 1'b1);
      run(32'hCAFE_0001, 1, 1'b0);
      run(32'h0000_0000, 0, 1'b0);
      run(32'hA5A5_3C3C, 2, 1'b0);
      run(32'h0BAD_F00D, 0, 1'b0);
      chk(n_pw > 0, "R4 partial writes occur", n_pw, 1);
      chk(n_rd > n_fw, "R4 reads favoured over full writes", n_rd, n_fw);
      finish_up();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      finish_up();
   end
endmodule